// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver with Break Detection

This block turns an asynchronous serial line into whole characters. It samples the line on a 16X bit-rate clock enable and checks each candidate start bit at its middle. It then gathers 5 to 8 data bits, least significant bit first, plus an optional parity bit and one stop bit. Each finished character goes to a downstream FIFO on a valid/ready stream. The character travels with three flags: parity error, framing error and compare match.

A line held low through a whole character, including the parity bit and the stop bit, is treated as a break and is not delivered as a character. A single-cycle pulse marks the start of the break. A second pulse marks the first sampled return of the line to high. When a stop bit is sampled low on an ordinary character, the search for the next start bit resumes half a bit time later, so a start bit that directly follows the bad stop bit is still caught.

Back-pressure: a character is handed over on a clock edge where `ch_valid` and `ch_ready` are both high. While `ch_ready` is low, `ch_valid` and all character fields hold steady. If another character completes while the held one is still unaccepted, the new character is discarded and `overrun` pulses for one cycle. The configuration inputs may change only while the line is idle and no character is held.

Top module: `uart_brk_rx`

## Requirements
- R1: After reset, `ch_valid`, `overrun`, `brk_begin` and `brk_over` are all low.
- R2: The character length is 5 plus `cfg_len` (0 to 3). Bits arrive least significant first and are placed from `ch_data[0]` upward. Data bits at or above the length read as zero.
- R3: `cfg_parity` selects the parity mode: 0 none, 1 even, 2 odd, 3 parity bit must be 0, 4 parity bit must be 1. `ch_perr` is set when the received parity bit breaks the selected rule. It is always 0 when the mode is none.
- R4: A low on the line that has gone high again by the mid-bit sample (8 ticks after detection) is dropped as a false start and produces no character.
- R5: A character whose stop bit is sampled low, and which is not a break, is delivered with `ch_ferr` set. The start-bit search resumes 8 ticks after that stop sample, so a start bit that immediately follows the bad stop bit is received correctly.
- R6: A character whose data bits and parity bit (if present) are all zero and whose stop bit is low is a break. It is not delivered, and `brk_begin` pulses once. `brk_over` pulses once when the line is next sampled high, and only after a `brk_begin`. Reception then continues normally.
- R7: `ch_match` is set when the received data equals the low character-length bits of `cfg_cmp`. Bits of `cfg_cmp` above the length are ignored.
- R8: While `ch_valid` is high and `ch_ready` is low, `ch_valid` stays high and the character fields stay unchanged.
- R9: A character that completes while an unaccepted character is held is dropped, and `overrun` pulses for one cycle. The held character is kept and delivered later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Character length minus 5 |
| cfg_parity | input | 3 | Parity mode code (R3) |
| cfg_cmp | input | 8 | Compare character |
| ch_valid | output | 1 | Character available |
| ch_ready | input | 1 | Downstream accepts the character |
| ch_data | output | 8 | Received data, right aligned |
| ch_perr | output | 1 | Parity error flag of the character |
| ch_ferr | output | 1 | Framing error flag of the character |
| ch_match | output | 1 | Character equals the compare value |
| overrun | output | 1 | Pulse: a completed character was dropped |
| brk_begin | output | 1 | Pulse: break detected |
| brk_over | output | 1 | Pulse: line returned high after a break |

## Verification
The line passes through a two-stage synchronizer. With a tick every clock, the start is therefore seen about three cycles after the falling edge. A character is judged at the stop-bit sample, roughly 16 times (1 + length + parity) plus 10 cycles after that edge. It appears on `ch_valid` one cycle later, and `brk_begin` pulses in that same cycle. `brk_over` follows about three cycles after the line rises. The bench does not chase those exact cycles. A scoreboard queue matches every handshake transfer in order against the expected character. Pulse counters are read whole bit times after the event that should have caused them, and before the next one. The checks for absence (false start, break, dropped overrun) compare the transfer count and the pulse counters at those points.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_EVEN = 3'd1,
    PAR_ODD  = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_FHALF,
    RX_BRK
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DW      = 8,
  parameter int OVS     = 16,
  parameter int MIN_LEN = 5,
  parameter int LENW    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            line,
  input  logic [LENW-1:0] cfg_len,
  input  logic            par_en,
  output logic            done,
  output logic [DW-1:0]   data,
  output logic            pbit,
  output logic            ferr,
  output logic            brk_begin,
  output logic            brk_over
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DW);
  localparam int HALF = OVS / 2;

  rx_state_e       state;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bidx;
  logic [BW-1:0]   last_idx;
  logic            full_bit;
  logic            half_bit;

  assign last_idx = BW'(MIN_LEN - 1) + BW'(cfg_len);
  assign full_bit = (cnt == CW'(OVS - 1));
  assign half_bit = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      bidx      <= '0;
      data      <= '0;
      pbit      <= 1'b0;
      ferr      <= 1'b0;
      done      <= 1'b0;
      brk_begin <= 1'b0;
      brk_over  <= 1'b0;
    end else begin
      done      <= 1'b0;
      brk_begin <= 1'b0;
      brk_over  <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!line) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (half_bit) begin
              cnt <= '0;
              if (line) begin
                state <= RX_IDLE;
              end else begin
                state <= RX_DATA;
                bidx  <= '0;
                data  <= '0;
                pbit  <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (full_bit) begin
              cnt        <= '0;
              data[bidx] <= line;
              if (bidx == last_idx) state <= par_en ? RX_PAR : RX_STOP;
              else                  bidx  <= bidx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (full_bit) begin
              cnt   <= '0;
              pbit  <= line;
              state <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (full_bit) begin
              cnt <= '0;
              if (line) begin
                done  <= 1'b1;
                ferr  <= 1'b0;
                state <= RX_IDLE;
              end else if ((data == '0) && !(par_en && pbit)) begin
                brk_begin <= 1'b1;
                state     <= RX_BRK;
              end else begin
                done  <= 1'b1;
                ferr  <= 1'b1;
                state <= RX_FHALF;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_FHALF: begin
            if (half_bit) begin
              cnt   <= '0;
              state <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_BRK: begin
            if (line) begin
              brk_over <= 1'b1;
              state    <= RX_IDLE;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_char_eval.sv
module rx_char_eval
  import uart_rx_pkg::*;
#(
  parameter int DW      = 8,
  parameter int MIN_LEN = 5,
  parameter int LENW    = 2
) (
  input  logic [DW-1:0]   data,
  input  logic            pbit,
  input  logic [LENW-1:0] cfg_len,
  input  logic [2:0]      cfg_parity,
  input  logic [DW-1:0]   cfg_cmp,
  output logic            par_en,
  output logic            perr,
  output logic            match
);
  logic [DW-1:0] mask;
  logic          ones;

  for (genvar g = 0; g < DW; g++) begin : g_mask
    assign mask[g] = (32'(g) < (32'(MIN_LEN) + 32'(cfg_len)));
  end

  assign ones  = ^(data & mask);
  assign match = (((data ^ cfg_cmp) & mask) == '0);

  always_comb begin
    par_en = 1'b1;
    perr   = 1'b0;
    case (cfg_parity)
      PAR_EVEN: perr = ones ^ pbit;
      PAR_ODD:  perr = ~(ones ^ pbit);
      PAR_ZERO: perr = pbit;
      PAR_ONE:  perr = ~pbit;
      default:  par_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/rx_hold.sv
module rx_hold #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word,
  output logic         drop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      drop      <= 1'b0;
    end else begin
      drop <= 1'b0;
      if (in_valid) begin
        if (out_valid && !out_ready) begin
          drop <= 1'b1;
        end else begin
          out_valid <= 1'b1;
          out_word  <= in_word;
        end
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx
  import uart_rx_pkg::*;
#(
  parameter int DW      = 8,
  parameter int OVS     = 16,
  parameter int MIN_LEN = 5,
  parameter int LENW    = 2,
  parameter int SYNC    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick16,
  input  logic            rxd,
  input  logic [LENW-1:0] cfg_len,
  input  logic [2:0]      cfg_parity,
  input  logic [DW-1:0]   cfg_cmp,
  output logic            ch_valid,
  input  logic            ch_ready,
  output logic [DW-1:0]   ch_data,
  output logic            ch_perr,
  output logic            ch_ferr,
  output logic            ch_match,
  output logic            overrun,
  output logic            brk_begin,
  output logic            brk_over
);
  localparam int WW = DW + 3;

  logic          line_s;
  logic          par_en;
  logic          f_done;
  logic [DW-1:0] f_data;
  logic          f_pbit;
  logic          f_ferr;
  logic          e_perr;
  logic          e_match;
  logic [WW-1:0] held;

  rx_sync #(.STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line_s)
  );

  rx_frame #(.DW(DW), .OVS(OVS), .MIN_LEN(MIN_LEN), .LENW(LENW)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick16),
    .line     (line_s),
    .cfg_len  (cfg_len),
    .par_en   (par_en),
    .done     (f_done),
    .data     (f_data),
    .pbit     (f_pbit),
    .ferr     (f_ferr),
    .brk_begin(brk_begin),
    .brk_over (brk_over)
  );

  rx_char_eval #(.DW(DW), .MIN_LEN(MIN_LEN), .LENW(LENW)) u_eval (
    .data      (f_data),
    .pbit      (f_pbit),
    .cfg_len   (cfg_len),
    .cfg_parity(cfg_parity),
    .cfg_cmp   (cfg_cmp),
    .par_en    (par_en),
    .perr      (e_perr),
    .match     (e_match)
  );

  rx_hold #(.W(WW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (f_done),
    .in_word  ({e_match, f_ferr, e_perr, f_data}),
    .out_valid(ch_valid),
    .out_ready(ch_ready),
    .out_word (held),
    .drop     (overrun)
  );

  assign ch_data  = held[DW-1:0];
  assign ch_perr  = held[DW];
  assign ch_ferr  = held[DW+1];
  assign ch_match = held[DW+2];
endmodule

// File: rtl/uart_brk_rx_sva.sv
module uart_brk_rx_sva #(
  parameter int DW      = 8,
  parameter int MIN_LEN = 5,
  parameter int LENW    = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [LENW-1:0] cfg_len,
  input logic            ch_valid,
  input logic            ch_ready,
  input logic [DW-1:0]   ch_data,
  input logic            ch_perr,
  input logic            ch_ferr,
  input logic            ch_match,
  input logic            overrun,
  input logic            brk_begin,
  input logic            brk_over
);
  logic in_brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_brk <= 1'b0;
    else if (brk_begin) in_brk <= 1'b1;
    else if (brk_over)  in_brk <= 1'b0;
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid && !ch_ready) |=> (ch_valid && $stable(ch_data) &&
      $stable({ch_perr, ch_ferr, ch_match})));

  a_r9_drop_only_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> ($past(ch_valid) && !$past(ch_ready) && ch_valid && $stable(ch_data)));

  a_r6_break_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brk_begin, brk_over}));

  a_r6_over_after_begin: assert property (@(posedge clk) disable iff (!rst_n)
    brk_over |-> in_brk);

  a_r6_no_char_on_begin: assert property (@(posedge clk) disable iff (!rst_n)
    brk_begin |-> !$rose(ch_valid));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid |-> ((32'(ch_data) >> (32'(MIN_LEN) + 32'(cfg_len))) == 0));
endmodule

bind uart_brk_rx uart_brk_rx_sva #(.DW(DW), .MIN_LEN(MIN_LEN), .LENW(LENW)) u_sva (.*);

// File: tb/uart_brk_rx_tb.sv
module uart_brk_rx_tb;
  localparam int BITC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic [2:0] cfg_parity = 3'd0;
  logic [7:0] cfg_cmp = 8'h00;
  logic       ch_ready = 1'b1;
  logic       ch_valid;
  logic [7:0] ch_data;
  logic       ch_perr, ch_ferr, ch_match;
  logic       overrun, brk_begin, brk_over;

  int checks = 0;
  int errors = 0;
  int n_taken = 0;
  int n_ovr = 0;
  int n_bb = 0;
  int n_bo = 0;
  bit finished = 1'b0;

  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  uart_brk_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_cmp(cfg_cmp),
    .ch_valid(ch_valid), .ch_ready(ch_ready), .ch_data(ch_data),
    .ch_perr(ch_perr), .ch_ferr(ch_ferr), .ch_match(ch_match),
    .overrun(overrun), .brk_begin(brk_begin), .brk_over(brk_over)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: scoreboard pop on each handshake, pulse counters
  always @(negedge clk) begin
    if (rst_n) begin
      if (overrun)   n_ovr++;
      if (brk_begin) n_bb++;
      if (brk_over)  n_bo++;
      if (ch_valid && ch_ready) begin
        logic [10:0] got;
        got = {ch_match, ch_ferr, ch_perr, ch_data};
        n_taken++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6/R9 unexpected character", int'(got), 0);
        end else begin
          logic [10:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, int'(got), int'(e));
        end
      end
    end
  end

  function automatic logic [7:0] lmask(input int len);
    return 8'hFF >> (8 - len);
  endfunction

  task automatic bit_out(input logic v);
    rxd = v;
    repeat (BITC) @(posedge clk);
    #1;
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) bit_out(1'b1);
  endtask

  // drive one frame; compute and optionally queue the expected result
  task automatic send_char(input logic [7:0] d, input int pmode, input bit flip,
                           input logic stopv, input bit push, input string tag);
    int len;
    logic [7:0] m;
    logic ones, p, perr, match;
    len   = 5 + int'(cfg_len);
    m     = lmask(len);
    ones  = ^(d & m);
    case (pmode)
      1: p = ones;
      2: p = ~ones;
      3: p = 1'b0;
      4: p = 1'b1;
      default: p = 1'b0;
    endcase
    p = p ^ flip;
    case (pmode)
      1: perr = ones ^ p;
      2: perr = ~(ones ^ p);
      3: perr = p;
      4: perr = ~p;
      default: perr = 1'b0;
    endcase
    match = (((d ^ cfg_cmp) & m) == 8'h00);
    if (push) begin
      exp_q.push_back({match, ~stopv, perr, d & m});
      tag_q.push_back(tag);
    end
    bit_out(1'b0);
    for (int i = 0; i < len; i++) bit_out(d[i]);
    if (pmode >= 1 && pmode <= 4) bit_out(p);
    bit_out(stopv);
  endtask

  task automatic drain(input string tag);
    int w = 0;
    while (exp_q.size() != 0 && w < 2000) begin
      @(posedge clk);
      w++;
    end
    #1;
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    int taken0;
    repeat (5) @(posedge clk);
    #1;
    @(negedge clk);
    // R1: reset state
    check(ch_valid == 1'b0, "R1 valid after reset", ch_valid, 0);
    check({overrun, brk_begin, brk_over} == 3'b000, "R1 pulses after reset",
          {overrun, brk_begin, brk_over}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    idle_bits(2);

    // R2: lengths, LSB first, upper bits zero
    cfg_len = 2'd3; cfg_parity = 3'd0;
    send_char(8'hA5, 0, 0, 1'b1, 1, "R2 len8 A5");
    send_char(8'h3C, 0, 0, 1'b1, 1, "R2 len8 3C");
    idle_bits(1);
    cfg_len = 2'd0;
    send_char(8'hE7, 0, 0, 1'b1, 1, "R2 len5 upper zero");
    cfg_len = 2'd1;
    send_char(8'h2B, 0, 0, 1'b1, 1, "R2 len6");
    idle_bits(1);
    drain("R2 drained");

    // R3: parity modes
    cfg_len = 2'd2;
    cfg_parity = 3'd1;
    send_char(8'h53, 1, 0, 1'b1, 1, "R3 even good");
    send_char(8'h53, 1, 1, 1'b1, 1, "R3 even bad");
    idle_bits(1);
    cfg_parity = 3'd2;
    send_char(8'h1F, 2, 0, 1'b1, 1, "R3 odd good");
    send_char(8'h1F, 2, 1, 1'b1, 1, "R3 odd bad");
    idle_bits(1);
    cfg_parity = 3'd3;
    send_char(8'h40, 3, 1, 1'b1, 1, "R3 force0 bit1");
    idle_bits(1);
    cfg_parity = 3'd4;
    send_char(8'h40, 4, 0, 1'b1, 1, "R3 force1 bit1");
    send_char(8'h40, 4, 1, 1'b1, 1, "R3 force1 bit0");
    idle_bits(1);
    drain("R3 drained");

    // R4: false start
    cfg_parity = 3'd0; cfg_len = 2'd3;
    taken0 = n_taken;
    rxd = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    rxd = 1'b1;
    idle_bits(3);
    @(negedge clk);
    check(n_taken == taken0 && !ch_valid, "R4 false start ignored", n_taken - taken0, 0);
    send_char(8'h96, 0, 0, 1'b1, 1, "R4 char after false start");
    idle_bits(1);
    drain("R4 drained");

    // R5: framing error, next start right after bad stop
    send_char(8'h5A, 0, 0, 1'b0, 1, "R5 ferr char");
    send_char(8'hC3, 0, 0, 1'b1, 1, "R5 char after half-bit restart");
    idle_bits(2);
    drain("R5 drained");

    // R6: break start/end
    cfg_parity = 3'd1;
    taken0 = n_taken;
    send_char(8'h00, 1, 0, 1'b0, 0, "R6 break");
    bit_out(1'b0);
    bit_out(1'b0);
    @(negedge clk);
    check(n_bb == 1, "R6 break begin count", n_bb, 1);
    check(n_bo == 0, "R6 no break end while low", n_bo, 0);
    check(n_taken == taken0 && !ch_valid, "R6 break not delivered", n_taken - taken0, 0);
    idle_bits(2);
    @(negedge clk);
    check(n_bo == 1, "R6 break end count", n_bo, 1);
    send_char(8'h81, 1, 0, 1'b1, 1, "R6 char after break");
    idle_bits(1);
    drain("R6 drained");

    // R7: compare match, upper cmp bits ignored
    cfg_parity = 3'd0; cfg_len = 2'd2; cfg_cmp = 8'hB5;
    send_char(8'h35, 0, 0, 1'b1, 1, "R7 match");
    send_char(8'h34, 0, 0, 1'b1, 1, "R7 no match");
    idle_bits(1);
    drain("R7 drained");

    // R8/R9: stall, hold, overrun
    cfg_len = 2'd3; cfg_cmp = 8'h00;
    ch_ready = 1'b0;
    send_char(8'h11, 0, 0, 1'b1, 1, "R9 held char kept");
    send_char(8'h22, 0, 0, 1'b1, 0, "R9 dropped");
    idle_bits(1);
    @(negedge clk);
    check(ch_valid && ch_data == 8'h11, "R8 held under stall", ch_data, 8'h11);
    check(n_ovr == 1, "R9 overrun pulse", n_ovr, 1);
    @(posedge clk); #1;
    ch_ready = 1'b1;
    drain("R9 drained");
    idle_bits(1);
    @(negedge clk);
    check(!ch_valid && n_ovr == 1, "R9 dropped char never shown", n_ovr, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule